// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block holds a small bank of performance counters that watch a memory controller. Counter 0 counts clock cycles and acts as the master timebase. The other counters each pick one event line from a vector of single-cycle event pulses, using an 8-bit event code. Software programs and reads the bank through a simple synchronous register port. Each counter has a control word and a read-only count word.

The cycle counter gates the whole bank. Event counters advance only while the cycle counter is enabled, armed and not frozen. When the cycle counter wraps, every counter freezes and the interrupt line rises. An event counter that reaches its limit saturates and stops on its own, with no interrupt. An 8-bit preload lets software start a count high in its range, which shortens the cycle counter's wrap period.

Top module: `mc_perf_bank`

## Requirements
- R1: After reset every count reads 0 and the interrupt is low. The cycle counter's control word reads 0x00000000, and each event counter's control word reads 0x00000002.
- R2: Counter n's control word is at byte offset 4*n and its count at 0x20 + 4*n. Read data is registered and appears the cycle after the read strobe. Any other offset reads 0.
- R3: Control word fields are: bit 0 overflow (read-only), bit 1 clear control, bit 2 enable, bits 23:16 preload, bits 31:24 event code. The cycle counter's event code always reads 0.
- R4: A write to an event counter with bit 1 = 0 loads its count with preload << PRE_SHIFT and clears its overflow. Bit 1 of that counter then reads 1.
- R5: A write to the cycle counter with bit 1 = 0 zeroes its count and overflow and disarms it; bit 1 reads 0. A disarmed cycle counter does not count even when enabled. A later write with bit 1 = 1 arms it and loads preload << PRE_SHIFT. A bit 1 = 1 write while armed leaves the count unchanged.
- R6: An enabled, armed, unfrozen cycle counter adds one on every clock edge. The edge that takes a register write does not count.
- R7: An event counter with code c (1 <= c < EVT_W) adds one on each edge where event bit c is high. It must be enabled and not overflowed, and the cycle counter must be running.
- R8: Event code 0, and codes at or above EVT_W, never advance an event counter.
- R9: An event counter at all-ones that sees another event sets its overflow bit and holds all-ones. It raises no interrupt and stays there until a clearing write.
- R10: When the cycle counter passes all-ones, it wraps to 0, sets its overflow bit and raises the interrupt. No counter changes while the interrupt is high.
- R11: The interrupt stays high until a write to the cycle counter's control word with bit 2 = 0. Enabling the cycle counter again lets the enabled event counters resume.
- R12: Writing 0 to a counter's enable bit stops it and keeps its value.
- R13: Writes to count offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | EVT_W | Single-cycle event pulses, bit index = event code |
| irq | output | 1 | Cycle-counter wrap interrupt |

## Verification
The assertions assume that reset is held for at least one edge before any access. They also assume that read and write strobes are never asserted together. The event vector is taken as ordinary synchronous data, with no meaning attached to how long a bit stays high. The bench drives every strobe on the falling clock edge and never overlaps a read with a write. It holds event bits high for exact edge counts, so the expected counts follow from edge arithmetic alone. It shrinks the count width, so saturation and wrap take a few hundred cycles rather than billions.

// File: rtl/mcpb_pkg.sv
package mcpb_pkg;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int PRE_LSB = 16;
  localparam int SEL_LSB = 24;

  typedef struct packed {
    logic [7:0] sel;
    logic [7:0] pre;
    logic       en;
    logic       clr;
  } ctrl_cmd_t;

  function automatic ctrl_cmd_t unpack_cmd(input logic [31:0] w);
    ctrl_cmd_t c;
    c.sel = w[SEL_LSB +: 8];
    c.pre = w[PRE_LSB +: 8];
    c.en  = w[EN_BIT];
    c.clr = w[CLR_BIT];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic [7:0] sel, input logic [7:0] pre,
                                            input logic en, input logic clr, input logic ovf);
    logic [31:0] w;
    w = '0;
    w[SEL_LSB +: 8] = sel;
    w[PRE_LSB +: 8] = pre;
    w[EN_BIT]  = en;
    w[CLR_BIT] = clr;
    w[OVF_BIT] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/mcpb_regif.sv
module mcpb_regif
  import mcpb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_CNT-1:0][31:0]      ctrl_words,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] counts,
  output logic [NUM_CNT-1:0]            wr_ctrl,
  output logic [31:0]                   rdata
);
  localparam int CTRL_BASE = 'h00;
  localparam int CNT_BASE  = 'h20;
  localparam int STRIDE    = 4;

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_wdec
      assign wr_ctrl[gi] = wr_en && (addr_ext == 32'(CTRL_BASE + STRIDE * gi));
    end
  endgenerate

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr_ext == 32'(CTRL_BASE + STRIDE * i)) rd_mux = ctrl_words[i];
      if (addr_ext == 32'(CNT_BASE + STRIDE * i))  rd_mux = 32'(counts[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R2: read data only changes after a read strobe
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/mcpb_cyc_cnt.sv
module mcpb_cyc_cnt
  import mcpb_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PRE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             w_en,
  input  logic             w_clr,
  input  logic [7:0]       w_pre,
  input  logic             frz,
  output logic [31:0]      ctrl_word,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             wrap
);
  logic             en_q, armed_q, ovf_q;
  logic [7:0]       pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign running = en_q && armed_q && !frz;
  assign wrap    = running && !wr && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; armed_q <= 1'b0; ovf_q <= 1'b0;
      pre_q <= '0;  cnt_q <= '0;
    end else if (wr) begin
      en_q  <= w_en;
      pre_q <= w_pre;
      if (!w_clr) begin
        cnt_q <= '0; ovf_q <= 1'b0; armed_q <= 1'b0;
      end else if (!armed_q) begin
        armed_q <= 1'b1;
        cnt_q   <= CNT_W'(w_pre) << PRE_SHIFT;
      end
    end else if (running) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == '1) ovf_q <= 1'b1;
    end
  end

  assign ctrl_word = pack_ctrl(8'h00, pre_q, en_q, armed_q, ovf_q);
  assign count     = cnt_q;

  // R5: a disarmed cycle counter holds its count
  p_disarm_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !wr) |=> $stable(cnt_q));
  // R10: passing all-ones lands on zero with overflow set
  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0) && ovf_q);
  // R6: without a write the count moves by at most one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/mcpb_evt_cnt.sv
module mcpb_evt_cnt
  import mcpb_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 64,
  parameter int PRE_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  ctrl_cmd_t        cmd,
  input  logic [EVT_W-1:0] evt,
  input  logic             run_ok,
  output logic [31:0]      ctrl_word,
  output logic [CNT_W-1:0] count
);
  logic             en_q, ovf_q;
  logic [7:0]       pre_q, sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [255:0]     evt_pad;
  logic             code_ok, hit;

  assign evt_pad = 256'(evt);
  assign code_ok = (sel_q != 8'd0) && (32'(sel_q) < EVT_W);
  assign hit     = code_ok && evt_pad[sel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; ovf_q <= 1'b0;
      pre_q <= '0;  sel_q <= '0; cnt_q <= '0;
    end else if (wr) begin
      en_q  <= cmd.en;
      pre_q <= cmd.pre;
      sel_q <= cmd.sel;
      if (!cmd.clr) begin
        cnt_q <= CNT_W'(cmd.pre) << PRE_SHIFT;
        ovf_q <= 1'b0;
      end
    end else if (en_q && !ovf_q && run_ok && hit) begin
      if (cnt_q == '1) ovf_q <= 1'b1;
      else             cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign ctrl_word = pack_ctrl(sel_q, pre_q, en_q, 1'b1, ovf_q);
  assign count     = cnt_q;

  // R9: a saturated counter stays put until rewritten
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !wr) |=> ovf_q && $stable(cnt_q));
  // R10: nothing moves while the master is not running
  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (!run_ok && !wr) |=> $stable(cnt_q));
  // R8: unmapped codes never advance
  p_nomap_r8: assert property (@(posedge clk) disable iff (rst)
    ((sel_q == 8'd0 || 32'(sel_q) >= EVT_W) && !wr) |=> $stable(cnt_q));
  // R7: count advances by at most one per edge
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/mc_perf_bank.sv
module mc_perf_bank
  import mcpb_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int CNT_W     = 32,
  parameter int EVT_W     = 64,
  parameter int PRE_SHIFT = 16,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq
);
  ctrl_cmd_t                    cmd;
  logic [NUM_CNT-1:0]           wr_ctrl;
  logic [NUM_CNT-1:0][31:0]     ctrl_words;
  logic [NUM_CNT-1:0][CNT_W-1:0] counts;
  logic                         cyc_run, cyc_wrap, irq_q;
  logic                         wdata_unused;

  assign cmd          = unpack_cmd(reg_wdata);
  assign wdata_unused = ^{reg_wdata[15:3], reg_wdata[0]};

  mcpb_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .ctrl_words(ctrl_words), .counts(counts), .wr_ctrl(wr_ctrl), .rdata(reg_rdata)
  );

  mcpb_cyc_cnt #(.CNT_W(CNT_W), .PRE_SHIFT(PRE_SHIFT)) u_cyc (
    .clk(clk), .rst(rst), .wr(wr_ctrl[0]), .w_en(cmd.en), .w_clr(cmd.clr),
    .w_pre(cmd.pre), .frz(irq_q), .ctrl_word(ctrl_words[0]), .count(counts[0]),
    .running(cyc_run), .wrap(cyc_wrap)
  );

  genvar gi;
  generate
    for (gi = 1; gi < NUM_CNT; gi++) begin : g_evt
      mcpb_evt_cnt #(.CNT_W(CNT_W), .EVT_W(EVT_W), .PRE_SHIFT(PRE_SHIFT)) u_evt (
        .clk(clk), .rst(rst), .wr(wr_ctrl[gi]), .cmd(cmd), .evt(evt_in),
        .run_ok(cyc_run), .ctrl_word(ctrl_words[gi]), .count(counts[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                        irq_q <= 1'b0;
    else if (wr_ctrl[0] && !cmd.en) irq_q <= 1'b0;
    else if (cyc_wrap)              irq_q <= 1'b1;
  end

  assign irq = irq_q;

  // R11: interrupt held until the cycle counter is disabled
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(wr_ctrl[0] && !cmd.en)) |=> irq_q);
  // R10: a wrap raises the interrupt on the next edge
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
    cyc_wrap |=> irq_q);
  // R13: count offsets never produce control writes
  p_cnt_wr_ignored_r13: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr >= ADDR_W'(8'h20)) |-> (wr_ctrl == '0));
endmodule

// File: tb/sim_mc_perf_bank.sv
`timescale 1ns/1ps
module sim_mc_perf_bank;
  localparam int CW = 16;
  localparam int EW = 16;

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [EW-1:0] evt_in = '0;
  logic irq;
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;

  mc_perf_bank #(.NUM_CNT(4), .CNT_W(CW), .EVT_W(EW), .PRE_SHIFT(8), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [31:0] ctl(input logic [7:0] sel, input logic [7:0] pre,
                                      input logic en, input logic clr);
    return {sel, pre, 13'b0, en, clr, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // {counter, code, event pattern, edges held, expected count}
  localparam logic [47:0] VEC [8] = '{
    {8'd1, 8'h03, 16'h0008, 8'd5, 8'd5},
    {8'd2, 8'h05, 16'h0020, 8'd7, 8'd7},
    {8'd3, 8'h0F, 16'h8000, 8'd3, 8'd3},
    {8'd1, 8'h04, 16'h0008, 8'd6, 8'd0},
    {8'd2, 8'h00, 16'hFFFF, 8'd4, 8'd0},
    {8'd3, 8'h20, 16'hFFFF, 8'd4, 8'd0},
    {8'd1, 8'h01, 16'h0002, 8'd9, 8'd9},
    {8'd3, 8'h0A, 16'hFFFF, 8'd2, 8'd2}
  };

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rdchk("R1 ctrl0", 8'h00, 32'h0);
    rdchk("R1 ctrl1", 8'h04, 32'h2);
    rdchk("R1 count0", 8'h20, 32'h0);
    rdchk("R1 count3", 8'h2C, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    // R2 unmapped offsets
    rdchk("R2 off40", 8'h40, 32'h0);
    rdchk("R2 off1C", 8'h1C, 32'h0);

    // R3/R5 code forced to 0, arming loads preload
    wr(8'h00, ctl(8'h55, 8'h12, 1'b0, 1'b1));
    rdchk("R3 ctrl0 fields", 8'h00, 32'h00120002);
    rdchk("R5 arm preload", 8'h20, 32'h1200);

    // start master timebase from zero
    wr(8'h00, 32'h0);
    wr(8'h00, ctl(8'h00, 8'h00, 1'b1, 1'b1));

    // R7/R8 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0] idx, sel, len, ex;
      logic [15:0] pat;
      {idx, sel, pat, len, ex} = VEC[i];
      wr(8'(4 * idx), ctl(sel, 8'h00, 1'b1, 1'b0));
      evt_in = pat;
      repeat (int'(len)) @(negedge clk);
      evt_in = '0;
      rdchk((ex == 0) ? "R8 vector" : "R7 vector", 8'(8'h20 + 4 * idx), {24'b0, ex});
    end

    // R13 writes to count offsets ignored
    rd(8'h24, v);
    wr(8'h24, 32'hABCD);
    rdchk("R13 count write ignored", 8'h24, v);

    // R12 disable keeps value
    wr(8'h04, ctl(8'h03, 8'h00, 1'b1, 1'b0));
    evt_in = 16'h0008;
    repeat (4) @(negedge clk);
    wr(8'h04, ctl(8'h03, 8'h00, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    evt_in = '0;
    rdchk("R12 event hold", 8'h24, 32'h4);
    rdchk("R12 ctrl1", 8'h04, 32'h03000002);

    // R4 clear loads preload; R9 saturation
    wr(8'h04, ctl(8'h03, 8'hFF, 1'b1, 1'b0));
    rdchk("R4 preload", 8'h24, 32'hFF00);
    rdchk("R4 clr reads 1", 8'h04, 32'h03FF0006);
    evt_in = 16'h0008;
    repeat (300) @(negedge clk);
    evt_in = '0;
    rdchk("R9 saturated", 8'h24, 32'hFFFF);
    rdchk("R9 ovf set", 8'h04, 32'h03FF0007);
    chk("R9 no irq", {31'b0, irq}, 32'h0);
    wr(8'h04, ctl(8'h03, 8'h00, 1'b1, 1'b0));
    rdchk("R4 ovf cleared", 8'h04, 32'h03000006);
    rdchk("R4 count cleared", 8'h24, 32'h0);

    // R5/R6 cycle counter
    wr(8'h00, 32'h0);
    wr(8'h00, ctl(8'h00, 8'h00, 1'b1, 1'b0));
    repeat (10) @(negedge clk);
    rdchk("R5 disarmed holds", 8'h20, 32'h0);
    rdchk("R5 disarmed ctrl", 8'h00, 32'h00000004);
    wr(8'h00, ctl(8'h00, 8'h10, 1'b1, 1'b1));
    repeat (20) @(negedge clk);
    wr(8'h00, ctl(8'h00, 8'h10, 1'b0, 1'b1));
    rdchk("R6 cycle count", 8'h20, 32'h1014);
    repeat (5) @(negedge clk);
    rdchk("R12 cycle hold", 8'h20, 32'h1014);

    // R10 wrap, freeze, interrupt
    wr(8'h00, 32'h0);
    evt_in = 16'h0004;
    wr(8'h08, ctl(8'h02, 8'h00, 1'b1, 1'b0));
    wr(8'h00, ctl(8'h00, 8'hFF, 1'b1, 1'b1));
    repeat (255) @(negedge clk);
    chk("R10 irq before wrap", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq at wrap", {31'b0, irq}, 32'h1);
    repeat (10) @(negedge clk);
    rdchk("R10 events frozen", 8'h28, 32'h100);
    rdchk("R10 cycle wrapped", 8'h20, 32'h0);
    rdchk("R10 cycle ovf", 8'h00, 32'h00FF0007);

    // R11 interrupt hold, release and resume
    repeat (20) @(negedge clk);
    chk("R11 irq held", {31'b0, irq}, 32'h1);
    wr(8'h00, ctl(8'h00, 8'hFF, 1'b0, 1'b1));
    chk("R11 irq released", {31'b0, irq}, 32'h0);
    repeat (5) @(negedge clk);
    rdchk("R11 stopped while master off", 8'h28, 32'h100);
    wr(8'h00, ctl(8'h00, 8'hFF, 1'b1, 1'b1));
    repeat (10) @(negedge clk);
    rdchk("R11 resumed", 8'h28, 32'h10A);
    evt_in = '0;

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule